// File: doc/BRIEF.md
# Multi-Hart Compare-Match Timer

This block keeps one 64-bit free-running time value for a small multi-core system and a 64-bit alarm register for each hart. Every hart gets a level interrupt line that is high whenever that hart's alarm value is at or below the current time, using an unsigned comparison. Software sets a hart's next alarm by writing its compare slot. Writing a value that has already passed raises the line. Writing a later value lowers the line until time catches up.

A plain register bus reaches both the time value and the compare slots. The bus has an address, a write strobe, 64-bit write data, a size flag that selects a 4-byte or 8-byte access, and combinational read data. Each 8-byte slot can be accessed as a full word at its first offset, or as two 32-bit halves that can be written separately. The time value advances by one on each cycle in which the external tick-enable is high. When software rewrites the time value, every hart's line is compared again against the new time.

Top module: `hart_timer`

## Requirements
- R1: After reset the time value reads zero and every interrupt output is low until the first clock edge after reset is released.
- R2: With no bus write to the time value, time increases by exactly one on each clock where `tick_en` is high, and holds when it is low.
- R3: A bus write to the time value in the same cycle as `tick_en` loads the written value, and the increment is lost for that cycle.
- R4: Each `irq_o[h]` equals, one clock later, the unsigned test compare[h] <= time. A compare value with bit 63 set counts as large, not as negative.
- R5: Compare slot h occupies the 8 bytes at `CMP_BASE + 8*h`, for h below `NUM_HARTS`. A write to one slot leaves every other slot unchanged.
- R6: A 4-byte write (`bus_len8`=0) at slot offset 0 replaces bits 31:0 and keeps bits 63:32. A 4-byte write at offset 4 replaces bits 63:32 with `bus_wdata[31:0]` and keeps bits 31:0. Both rules apply to compare slots and to the time value.
- R7: An 8-byte write (`bus_len8`=1) at offset 0 replaces all 64 bits, and an 8-byte read there returns all 64 bits.
- R8: An 8-byte write at offset 4 of a compare slot or of the time value is ignored.
- R9: A 4-byte read at offset 0 returns bits 31:0 zero-extended. A read of either size at offset 4 returns bits 63:32 in `bus_rdata[31:0]`, with the upper half zero.
- R10: Reads at any unmapped address return zero, and writes there change nothing. Unmapped addresses include offsets other than 0 and 4 within an 8-byte group, addresses beyond the last compare slot, and addresses outside the time window.
- R11: After any write to the time value, every hart's interrupt reflects the new time from the following clock.
- R12: Writing a compare value above the current time lowers that hart's interrupt one clock later. The line stays low until time reaches the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advance the time value by one this cycle |
| bus_we | input | 1 | Write strobe for the current address |
| bus_len8 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 64 | Write data, little-endian |
| bus_rdata | output | 64 | Combinational read data for `bus_addr` |
| irq_o | output | NUM_HARTS | Level timer interrupt, one per hart |

## Verification
The bench targets the half-word merge rules. It writes high and low halves in turn and reads back the full word, so a design that zeroed the other half, or swapped the halves, returns the wrong 64-bit value. It issues an 8-byte write at offset 4, a write at a misaligned offset, and a write just past the last slot, and then reads back the neighbouring slots; a decoder that truncated the address would corrupt another slot. The interrupt tests step time across the exact compare value one tick at a time. They also place a compare value with bit 63 set, which catches a signed comparator, an off-by-one using a strict less-than, and a missing recompare after a time write. A tick and a time write in the same cycle show whether the increment wrongly takes priority.

// File: rtl/ht_pkg.sv
package ht_pkg;

   localparam int unsigned WORD_W = 64;
   localparam int unsigned HALF_W = WORD_W / 2;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_TIME = 2'd1,
      SEL_CMP  = 2'd2
   } ht_sel_e;

   // Merge a write into a 64-bit register according to access size and half.
   function automatic logic [WORD_W-1:0] ht_merge(
      input logic [WORD_W-1:0] cur,
      input logic [WORD_W-1:0] wd,
      input logic              len8,
      input logic              hi
   );
      logic [WORD_W-1:0] res;
      if (len8)
         res = wd;
      else if (hi)
         res = {wd[HALF_W-1:0], cur[HALF_W-1:0]};
      else
         res = {cur[WORD_W-1:HALF_W], wd[HALF_W-1:0]};
      return res;
   endfunction

   // Shape a 64-bit register for the read bus.
   function automatic logic [WORD_W-1:0] ht_shape(
      input logic [WORD_W-1:0] v,
      input logic              len8,
      input logic              hi
   );
      logic [WORD_W-1:0] res;
      if (hi)
         res = {{HALF_W{1'b0}}, v[WORD_W-1:HALF_W]};
      else if (len8)
         res = v;
      else
         res = {{HALF_W{1'b0}}, v[HALF_W-1:0]};
      return res;
   endfunction

endpackage

// File: rtl/ht_addr_dec.sv
module ht_addr_dec
   import ht_pkg::*;
#(
   parameter int unsigned           ADDR_W    = 12,
   parameter int unsigned           NUM_HARTS = 4,
   parameter int unsigned           IDX_W     = 2,
   parameter logic [ADDR_W-1:0]     CMP_BASE  = '0,
   parameter logic [ADDR_W-1:0]     TIME_BASE = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output ht_sel_e           sel,
   output logic              hi,
   output logic [IDX_W-1:0]  idx
);

   localparam int unsigned       SPAN_B  = NUM_HARTS * 8;
   localparam logic [ADDR_W:0]   SPAN_V  = (ADDR_W+1)'(SPAN_B);

   logic [ADDR_W-1:0] rel;
   logic              in_cmp;
   logic              in_time;
   logic              word_ok;

   always_comb begin
      rel     = addr - CMP_BASE;
      in_cmp  = (addr >= CMP_BASE) && ({1'b0, rel} < SPAN_V);
      in_time = (addr[ADDR_W-1:3] == TIME_BASE[ADDR_W-1:3]);
      word_ok = (addr[1:0] == 2'b00);
      hi      = addr[2];
      idx     = rel[IDX_W+2:3];
      if (!word_ok)
         sel = SEL_NONE;
      else if (in_cmp)
         sel = SEL_CMP;
      else if (in_time)
         sel = SEL_TIME;
      else
         sel = SEL_NONE;
   end

endmodule

// File: rtl/ht_time_ctr.sv
module ht_time_ctr
   import ht_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              len8,
   input  logic              hi,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] time_o
);

   logic [WORD_W-1:0] time_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         time_q <= '0;
      else if (wr_en)
         time_q <= ht_merge(time_q, wdata, len8, hi);
      else if (tick_en)
         time_q <= time_q + WORD_W'(1);
   end

   assign time_o = time_q;

endmodule

// File: rtl/ht_cmp_slot.sv
module ht_cmp_slot
   import ht_pkg::*;
#(
   parameter bit SPLIT_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              len8,
   input  logic              hi,
   input  logic [WORD_W-1:0] wdata,
   input  logic [WORD_W-1:0] time_i,
   output logic [WORD_W-1:0] cmp_o,
   output logic              irq_o
);

   logic [WORD_W-1:0] cmp_q;
   logic              reached;
   logic              irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cmp_q <= '0;
      else if (wr_en)
         cmp_q <= ht_merge(cmp_q, wdata, len8, hi);
   end

   generate
      if (SPLIT_CMP) begin : g_split
         // Two 32-bit comparators in parallel, combined in one level.
         logic hi_lt, hi_eq, lo_le;
         always_comb begin
            hi_lt   = cmp_q[WORD_W-1:HALF_W] <  time_i[WORD_W-1:HALF_W];
            hi_eq   = cmp_q[WORD_W-1:HALF_W] == time_i[WORD_W-1:HALF_W];
            lo_le   = cmp_q[HALF_W-1:0]      <= time_i[HALF_W-1:0];
            reached = hi_lt | (hi_eq & lo_le);
         end
      end else begin : g_flat
         always_comb reached = (cmp_q <= time_i);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= reached;
   end

   assign cmp_o = cmp_q;
   assign irq_o = irq_q;

endmodule

// File: rtl/hart_timer.sv
module hart_timer
   import ht_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 12,
   parameter int unsigned       NUM_HARTS = 4,
   parameter logic [ADDR_W-1:0] CMP_BASE  = 12'h000,
   parameter logic [ADDR_W-1:0] TIME_BASE = 12'h100,
   parameter bit                SPLIT_CMP = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 bus_we,
   input  logic                 bus_len8,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [63:0]          bus_wdata,
   output logic [63:0]          bus_rdata,
   output logic [NUM_HARTS-1:0] irq_o
);

   localparam int unsigned IDX_W  = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
   localparam int unsigned SPAN_B = NUM_HARTS * 8;

   // Elaboration-time parameter checks
   generate
      if (NUM_HARTS < 1) begin : g_bad_harts
         $error("hart_timer: NUM_HARTS must be at least 1");
      end
      if (ADDR_W < IDX_W + 3) begin : g_bad_aw
         $error("hart_timer: ADDR_W too narrow for the compare array");
      end
      if (CMP_BASE[2:0] != 3'b000 || TIME_BASE[2:0] != 3'b000) begin : g_bad_align
         $error("hart_timer: bases must be 8-byte aligned");
      end
      if ((int'(TIME_BASE) >= int'(CMP_BASE)) &&
          (int'(TIME_BASE) <  int'(CMP_BASE) + int'(SPAN_B))) begin : g_bad_overlap
         $error("hart_timer: time window overlaps the compare array");
      end
      if (int'(CMP_BASE) + int'(SPAN_B) > (1 << ADDR_W)) begin : g_bad_span
         $error("hart_timer: compare array exceeds the address space");
      end
   endgenerate

   ht_sel_e                         sel;
   logic                            sel_hi;
   logic [IDX_W-1:0]                sel_idx;
   logic                            wr_ok;
   logic                            time_wr;
   logic [WORD_W-1:0]               time_q;
   logic [NUM_HARTS-1:0][WORD_W-1:0] cmp_q;

   ht_addr_dec #(
      .ADDR_W    (ADDR_W),
      .NUM_HARTS (NUM_HARTS),
      .IDX_W     (IDX_W),
      .CMP_BASE  (CMP_BASE),
      .TIME_BASE (TIME_BASE)
   ) dec_i (
      .addr (bus_addr),
      .sel  (sel),
      .hi   (sel_hi),
      .idx  (sel_idx)
   );

   // An 8-byte access at the upper offset is not a legal write.
   assign wr_ok   = bus_we && (sel != SEL_NONE) && !(bus_len8 && sel_hi);
   assign time_wr = wr_ok && (sel == SEL_TIME);

   ht_time_ctr time_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_en   (time_wr),
      .len8    (bus_len8),
      .hi      (sel_hi),
      .wdata   (bus_wdata),
      .time_o  (time_q)
   );

   generate
      for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
         logic slot_wr;
         assign slot_wr = wr_ok && (sel == SEL_CMP) && (sel_idx == IDX_W'(h));

         ht_cmp_slot #(
            .SPLIT_CMP (SPLIT_CMP)
         ) slot_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (slot_wr),
            .len8   (bus_len8),
            .hi     (sel_hi),
            .wdata  (bus_wdata),
            .time_i (time_q),
            .cmp_o  (cmp_q[h]),
            .irq_o  (irq_o[h])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_TIME: bus_rdata = ht_shape(time_q, bus_len8, sel_hi);
         SEL_CMP: begin
            if (int'(sel_idx) < NUM_HARTS)
               bus_rdata = ht_shape(cmp_q[sel_idx], bus_len8, sel_hi);
         end
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/hart_timer_chk.sv
module hart_timer_chk #(
   parameter int unsigned       ADDR_W    = 12,
   parameter int unsigned       NUM_HARTS = 4,
   parameter logic [ADDR_W-1:0] CMP_BASE  = 12'h000,
   parameter logic [ADDR_W-1:0] TIME_BASE = 12'h100
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          tick_en,
   input logic                          bus_we,
   input logic                          bus_len8,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic [63:0]                   bus_wdata,
   input logic [63:0]                   bus_rdata,
   input logic [63:0]                   time_q,
   input logic [NUM_HARTS-1:0][63:0]    cmp_q,
   input logic [NUM_HARTS-1:0]          irq_o
);

   localparam logic [ADDR_W:0] CMP_END = (ADDR_W+1)'(int'(CMP_BASE) + NUM_HARTS * 8);

   logic in_cmp_c, in_time_c, mapped_c;

   always_comb begin
      in_cmp_c  = ({1'b0, bus_addr} >= {1'b0, CMP_BASE}) && ({1'b0, bus_addr} < CMP_END);
      in_time_c = ({1'b0, bus_addr} == {1'b0, TIME_BASE}) ||
                  ({1'b0, bus_addr} == {1'b0, TIME_BASE} + (ADDR_W+1)'(4));
      mapped_c  = (bus_addr[1:0] == 2'b00) && (in_cmp_c || in_time_c);
   end

   // R2: time steps by one on a tick when the bus is not writing
   assert_time_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && tick_en) |=> (time_q == $past(time_q) + 64'd1));

   // R2: time holds with no tick and no write
   assert_time_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && !tick_en) |=> $stable(time_q));

   // R3: a full-word time write wins over a simultaneous tick
   assert_time_write_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_len8 && (bus_addr == TIME_BASE)) |=> (time_q == $past(bus_wdata)));

   // R8: 8-byte write at the upper offset of a compare slot is ignored
   assert_cmp_wide_hi_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_len8 && in_cmp_c && (bus_addr[2:0] == 3'b100)) |=> $stable(cmp_q));

   // R10: unmapped reads return zero
   assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped_c |-> (bus_rdata == 64'd0));

   // R4: each interrupt follows the unsigned compare one clock later
   generate
      for (genvar h = 0; h < NUM_HARTS; h++) begin : g_irq_chk
         assert_irq_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o[h] == ($past(cmp_q[h]) <= $past(time_q))));
      end
   endgenerate

endmodule

bind hart_timer hart_timer_chk #(
   .ADDR_W    (ADDR_W),
   .NUM_HARTS (NUM_HARTS),
   .CMP_BASE  (CMP_BASE),
   .TIME_BASE (TIME_BASE)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .bus_we    (bus_we),
   .bus_len8  (bus_len8),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .time_q    (time_q),
   .cmp_q     (cmp_q),
   .irq_o     (irq_o)
);

// File: tb/hart_timer_tb_top.sv
module hart_timer_tb_top;

   localparam int unsigned AW     = 12;
   localparam int unsigned NH     = 4;
   localparam logic [AW-1:0] CB   = 12'h000;
   localparam logic [AW-1:0] TB   = 12'h100;

   typedef struct packed {
      logic          rd;
      logic          len8;
      logic [AW-1:0] addr;
      logic [63:0]   data;
      logic [31:0]   tag;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b1, 12'h008, 64'h1111_2222_3333_4444, "R7"},
      '{1'b1, 1'b1, 12'h008, 64'h1111_2222_3333_4444, "R7"},
      '{1'b0, 1'b0, 12'h00C, 64'h0000_0000_AAAA_BBBB, "R6"},
      '{1'b1, 1'b1, 12'h008, 64'hAAAA_BBBB_3333_4444, "R6"},
      '{1'b0, 1'b0, 12'h008, 64'h0000_0000_CCCC_DDDD, "R6"},
      '{1'b1, 1'b1, 12'h008, 64'hAAAA_BBBB_CCCC_DDDD, "R6"},
      '{1'b1, 1'b1, 12'h00C, 64'h0000_0000_AAAA_BBBB, "R9"},
      '{1'b1, 1'b0, 12'h008, 64'h0000_0000_CCCC_DDDD, "R9"},
      '{1'b0, 1'b1, 12'h00C, 64'hFFFF_FFFF_FFFF_FFFF, "R8"},
      '{1'b1, 1'b1, 12'h008, 64'hAAAA_BBBB_CCCC_DDDD, "R8"},
      '{1'b0, 1'b1, 12'h018, 64'h0000_0000_0000_0055, "R5"},
      '{1'b1, 1'b1, 12'h018, 64'h0000_0000_0000_0055, "R5"},
      '{1'b1, 1'b1, 12'h010, 64'h0000_0000_0000_0000, "R5"},
      '{1'b1, 1'b1, 12'h000, 64'h0000_0000_0000_0000, "R5"},
      '{1'b0, 1'b1, 12'h020, 64'h0000_0000_0000_0077, "R10"},
      '{1'b1, 1'b1, 12'h020, 64'h0000_0000_0000_0000, "R10"},
      '{1'b0, 1'b0, 12'h009, 64'h0000_0000_1234_5678, "R10"},
      '{1'b1, 1'b1, 12'h008, 64'hAAAA_BBBB_CCCC_DDDD, "R10"},
      '{1'b1, 1'b0, 12'h009, 64'h0000_0000_0000_0000, "R10"},
      '{1'b0, 1'b1, 12'h100, 64'h0000_0001_0000_0000, "R7"},
      '{1'b1, 1'b1, 12'h100, 64'h0000_0001_0000_0000, "R7"},
      '{1'b0, 1'b0, 12'h104, 64'h0000_0000_0000_0002, "R6"},
      '{1'b1, 1'b1, 12'h100, 64'h0000_0002_0000_0000, "R6"},
      '{1'b0, 1'b0, 12'h100, 64'h0000_0000_0000_0010, "R6"},
      '{1'b1, 1'b1, 12'h100, 64'h0000_0002_0000_0010, "R6"},
      '{1'b0, 1'b1, 12'h104, 64'hFFFF_FFFF_FFFF_FFFF, "R8"},
      '{1'b1, 1'b1, 12'h100, 64'h0000_0002_0000_0010, "R8"},
      '{1'b1, 1'b0, 12'h104, 64'h0000_0000_0000_0002, "R9"},
      '{1'b1, 1'b1, 12'h108, 64'h0000_0000_0000_0000, "R10"}
   };

   logic          clk;
   logic          rst_n;
   logic          tick_en;
   logic          bus_we;
   logic          bus_len8;
   logic [AW-1:0] bus_addr;
   logic [63:0]   bus_wdata;
   logic [63:0]   bus_rdata;
   logic [NH-1:0] irq_o;

   int checks;
   int errors;
   bit done;

   hart_timer #(
      .ADDR_W    (AW),
      .NUM_HARTS (NH),
      .CMP_BASE  (CB),
      .TIME_BASE (TB)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_we    (bus_we),
      .bus_len8  (bus_len8),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [63:0] d, input logic l8);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_len8 = l8;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic l8, output logic [63:0] d);
      @(negedge clk);
      bus_addr = a; bus_len8 = l8;
      #2;
      d = bus_rdata;
   endtask

   task automatic tick(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] rv;
      checks = 0; errors = 0; done = 1'b0;
      rst_n = 1'b0; tick_en = 1'b0; bus_we = 1'b0; bus_len8 = 1'b0;
      bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      bus_addr = TB; bus_len8 = 1'b1;
      #2;
      check("R1 time after reset", bus_rdata, 64'd0);
      check("R1 irq after reset", 64'(irq_o), 64'd0);
      idle(1);
      check("R4 irq with zero compare", 64'(irq_o), 64'hF);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].rd) begin
            rd(VECS[i].addr, VECS[i].len8, rv);
            checks++;
            if (rv !== VECS[i].data) begin
               errors++;
               $display("FAIL %s vector %0d actual=%h expected=%h",
                        VECS[i].tag, i, rv, VECS[i].data);
            end
         end else begin
            wr(VECS[i].addr, VECS[i].data, VECS[i].len8);
         end
      end

      // R2: tick counting and holding
      wr(TB, 64'd100, 1'b1);
      tick(5);
      rd(TB, 1'b1, rv);
      check("R2 five ticks", rv, 64'd105);
      idle(3);
      rd(TB, 1'b1, rv);
      check("R2 hold without tick", rv, 64'd105);

      // R3: write and tick in the same cycle
      @(negedge clk);
      tick_en = 1'b1; bus_we = 1'b1; bus_addr = TB; bus_len8 = 1'b1; bus_wdata = 64'd500;
      @(negedge clk);
      tick_en = 1'b0; bus_we = 1'b0;
      rd(TB, 1'b1, rv);
      check("R3 write beats tick", rv, 64'd500);

      // R4 / R12: crossing the compare value, unsigned compare
      wr(TB, 64'd1000, 1'b1);
      wr(CB + 12'h000, 64'd1010, 1'b1);
      wr(CB + 12'h010, 64'h8000_0000_0000_0000, 1'b1);
      idle(1);
      check("R4 unsigned compare, mixed harts", 64'(irq_o), 64'h8);
      tick(9);
      idle(1);
      check("R12 one below compare", 64'(irq_o[0]), 64'd0);
      tick(1);
      idle(1);
      check("R4 compare reached", 64'(irq_o[0]), 64'd1);
      wr(CB, 64'd2000, 1'b1);
      idle(1);
      check("R12 future compare lowers irq", 64'(irq_o[0]), 64'd0);
      wr(CB, 64'd5, 1'b1);
      idle(1);
      check("R4 past compare raises irq", 64'(irq_o[0]), 64'd1);

      // R11: time rewrite re-evaluates all harts
      wr(TB, 64'd500, 1'b1);
      for (int h = 0; h < NH; h++) wr(CB + AW'(8 * h), 64'h0000_0001_0000_0100, 1'b1);
      idle(1);
      check("R12 all compares ahead", 64'(irq_o), 64'd0);
      wr(TB + 12'h004, 64'd1, 1'b0);
      idle(1);
      check("R11 all harts after time write", 64'(irq_o), 64'hF);
      rd(TB, 1'b1, rv);
      check("R6 time high half write", rv, 64'h0000_0001_0000_01F4);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule